// File: doc/BRIEF.md
# NOR Flash Command Write Sequencer

This block converts one command request into the series of bus write cycles that an asynchronous parallel NOR flash needs before it will act on a command. Most of these commands are small fixed scripts. Each script starts with a two-write unlock pair, then writes one or more command bytes to fixed word addresses. Some scripts end with a write to an address or a data word that the caller supplies. The sequencer drives one write at a time onto a simple memory bus port. It holds that write until the port acknowledges it. It pulses `done` when the final write of the script has been taken.

A requester presents a command code, a target word address and a data word under a valid/ready handshake. While a script is running, `busy` is high and every new request is refused. A refused request leaves the running script unchanged. Command word addresses are turned into bus byte addresses as follows: shift left by one for a 16-bit device or by zero for an 8-bit device, then add a bank base address. Both the device width and the bank base are parameters. Pin-level timing, status polling and reading back ID or query data are left to other blocks.

Top module: `nor_cmd_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle and `req_cmd` is a supported code. The supported codes are 0 return-to-read, 1 ID entry, 2 word program, 3 block erase, 4 chip erase and 5 query entry. Codes 6 and 7 are never accepted.
- R2: Commands 1, 2, 3 and 4 begin with data 0xAA to word 0x555, followed by data 0x55 to word 0x2AA.
- R3: Word program writes 0xA0 to word 0x555 after the unlock pair. Its fourth and last write puts `req_data` at `req_addr`.
- R4: ID entry is three writes, and the third is 0x90 to word 0x555.
- R5: Block erase is six writes. After the unlock pair it writes 0x80@0x555, then 0xAA@0x555, then 0x55@0x2AA, and finally 0x30 at `req_addr`.
- R6: Chip erase repeats the first five writes of block erase. Its sixth write is 0x10 to word 0x555.
- R7: Query entry is a single write of 0x98 to word 0x055, with no unlock pair.
- R8: Return-to-read is a single write of 0xF0 to word 0, which is the bank base.
- R9: `bus_addr` equals BANK_BASE + (word << S), where S is 1 for DEV_WIDTH 16 and 0 for DEV_WIDTH 8. Command bytes appear zero-extended on `bus_wdata`.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr` and `bus_wdata` hold their values. The script moves to its next write only on a cycle with `bus_req` and `bus_ack` both high. `bus_ack` has no effect while `bus_req` is low.
- R11: `done` is a one-cycle pulse in the cycle after the last write is acknowledged. `busy` and `bus_req` are low in that same cycle.
- R12: A request presented while `busy` is high is not accepted. The captured command, address and data stay unchanged.
- R13: After reset, `busy`, `done` and `bus_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_cmd | input | 3 | Command code |
| req_addr | input | WORD_W | Target word address (program word, erase block) |
| req_data | input | DATA_W | Data word for program |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse at end of script |
| bus_req | output | 1 | Write request to memory bus |
| bus_addr | output | ADDR_W | Byte address of current write |
| bus_wdata | output | DATA_W | Data of current write |
| bus_ack | input | 1 | Bus accepted current write |

## Verification
The end of one script and the acceptance of the next can fall in the same cycle. In the cycle where `done` pulses, `busy` is already low, so a request that is held valid is taken at once and its first write appears one cycle later. The bench provokes this by keeping requests valid while scripts run. It also randomises acknowledge delays, so final writes are taken in varied cycles. A behavioural model decides for every clock whether the done pulse and the new acceptance coincide. It then checks `done`, `busy`, `req_ready` and the first write of the next script against that model. Junk requests are also injected during busy cycles, so that refusals overlap script progress.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int STEP_W  = 3;
  localparam int MAGIC_W = 11;

  localparam logic [MAGIC_W-1:0] W_KEY_A = 11'h555;
  localparam logic [MAGIC_W-1:0] W_KEY_B = 11'h2AA;
  localparam logic [MAGIC_W-1:0] W_QUERY = 11'h055;

  typedef enum logic [2:0] {
    OP_READ_RST   = 3'd0,
    OP_IDENT      = 3'd1,
    OP_PROG       = 3'd2,
    OP_BLK_ERASE  = 3'd3,
    OP_CHIP_ERASE = 3'd4,
    OP_QUERY      = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SRC_MAGIC = 2'd0,
    SRC_USER  = 2'd1,
    SRC_BASE  = 2'd2
  } asrc_e;

  typedef struct packed {
    asrc_e              asrc;
    logic [MAGIC_W-1:0] word;
    logic               user_data;
    logic [7:0]         code;
    logic               last;
  } row_t;

  function automatic logic op_known(logic [2:0] c);
    return c <= 3'd5;
  endfunction

  function automatic logic [STEP_W-1:0] op_len(op_e op);
    case (op)
      OP_IDENT:      return 3'd3;
      OP_PROG:       return 3'd4;
      OP_BLK_ERASE:  return 3'd6;
      OP_CHIP_ERASE: return 3'd6;
      default:       return 3'd1;
    endcase
  endfunction

  function automatic row_t mk_row(asrc_e s, logic [MAGIC_W-1:0] w, logic u, logic [7:0] c);
    row_t r;
    r.asrc      = s;
    r.word      = w;
    r.user_data = u;
    r.code      = c;
    r.last      = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/nor_seq_script.sv
module nor_seq_script
  import nor_seq_pkg::*;
(
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  output row_t              row
);

  row_t body;

  always_comb begin
    body = mk_row(SRC_BASE, '0, 1'b0, 8'hF0);
    case (op)
      OP_QUERY: body = mk_row(SRC_MAGIC, W_QUERY, 1'b0, 8'h98);
      OP_IDENT: begin
        case (step)
          3'd0:    body = mk_row(SRC_MAGIC, W_KEY_A, 1'b0, 8'hAA);
          3'd1:    body = mk_row(SRC_MAGIC, W_KEY_B, 1'b0, 8'h55);
          default: body = mk_row(SRC_MAGIC, W_KEY_A, 1'b0, 8'h90);
        endcase
      end
      OP_PROG: begin
        case (step)
          3'd0:    body = mk_row(SRC_MAGIC, W_KEY_A, 1'b0, 8'hAA);
          3'd1:    body = mk_row(SRC_MAGIC, W_KEY_B, 1'b0, 8'h55);
          3'd2:    body = mk_row(SRC_MAGIC, W_KEY_A, 1'b0, 8'hA0);
          default: body = mk_row(SRC_USER,  '0,      1'b1, 8'h00);
        endcase
      end
      OP_BLK_ERASE, OP_CHIP_ERASE: begin
        case (step)
          3'd0: body = mk_row(SRC_MAGIC, W_KEY_A, 1'b0, 8'hAA);
          3'd1: body = mk_row(SRC_MAGIC, W_KEY_B, 1'b0, 8'h55);
          3'd2: body = mk_row(SRC_MAGIC, W_KEY_A, 1'b0, 8'h80);
          3'd3: body = mk_row(SRC_MAGIC, W_KEY_A, 1'b0, 8'hAA);
          3'd4: body = mk_row(SRC_MAGIC, W_KEY_B, 1'b0, 8'h55);
          default: begin
            if (op == OP_BLK_ERASE) body = mk_row(SRC_USER, '0, 1'b0, 8'h30);
            else                    body = mk_row(SRC_MAGIC, W_KEY_A, 1'b0, 8'h10);
          end
        endcase
      end
      default: body = mk_row(SRC_BASE, '0, 1'b0, 8'hF0);
    endcase
    row      = body;
    row.last = (step == (op_len(op) - 3'd1));
  end

endmodule

// File: rtl/nor_seq_addrmap.sv
module nor_seq_addrmap
  import nor_seq_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          WORD_W    = 20,
  parameter int          DEV_WIDTH = 16,
  parameter logic [23:0] BANK_BASE = 24'h40_0000
) (
  input  asrc_e              asrc,
  input  logic [MAGIC_W-1:0] magic_word,
  input  logic [WORD_W-1:0]  user_word,
  output logic [ADDR_W-1:0]  byte_addr
);

  logic [WORD_W-1:0] word_sel;
  logic [ADDR_W-1:0] word_ext;

  always_comb begin
    case (asrc)
      SRC_MAGIC: word_sel = WORD_W'(magic_word);
      SRC_USER:  word_sel = user_word;
      default:   word_sel = '0;
    endcase
    word_ext = ADDR_W'(word_sel);
  end

  generate
    if (DEV_WIDTH == 16) begin : g_wide
      assign byte_addr = ADDR_W'(BANK_BASE) + (word_ext << 1);
    end else begin : g_narrow
      assign byte_addr = ADDR_W'(BANK_BASE) + word_ext;
    end
  endgenerate

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  op_e               in_op,
  input  logic [WORD_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack,
  input  logic              last,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] step,
  output op_e               op_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_e;

  st_e               st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_d, done_q;
  logic              load_en, step_en;

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    step_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_RUN;
          step_d  = '0;
          load_en = 1'b1;
          step_en = 1'b1;
        end
      end
      default: begin
        if (ack) begin
          step_en = 1'b1;
          if (last) begin
            st_d   = ST_IDLE;
            step_d = '0;
            done_d = 1'b1;
          end else begin
            step_d = step_q + 3'd1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (step_en) step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_READ_RST;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      op_q   <= in_op;
      addr_q <= in_addr;
      data_q <= in_data;
    end
  end

  assign busy = (st_q == ST_RUN);
  assign done = done_q;
  assign step = step_q;

  // R5/R6: the step index never runs past the script length
  a_r5_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q < op_len(op_q)));

  // R11: a done pulse is never longer than one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          WORD_W    = 20,
  parameter int          DATA_W    = 16,
  parameter int          DEV_WIDTH = 16,
  parameter logic [23:0] BANK_BASE = 24'h40_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [WORD_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack
);

  logic              accept;
  logic [STEP_W-1:0] step;
  op_e               op_q;
  logic [WORD_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  row_t              row;

  assign req_ready = !busy && op_known(req_cmd);
  assign accept    = req_valid && req_ready;

  nor_seq_ctrl #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .in_op   (op_e'(req_cmd)),
    .in_addr (req_addr),
    .in_data (req_data),
    .ack     (bus_ack),
    .last    (row.last),
    .busy    (busy),
    .done    (done),
    .step    (step),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .data_q  (data_q)
  );

  nor_seq_script u_script (
    .op   (op_q),
    .step (step),
    .row  (row)
  );

  nor_seq_addrmap #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEV_WIDTH(DEV_WIDTH), .BANK_BASE(BANK_BASE)
  ) u_addrmap (
    .asrc       (row.asrc),
    .magic_word (row.word),
    .user_word  (addr_q),
    .byte_addr  (bus_addr)
  );

  assign bus_req   = busy;
  assign bus_wdata = row.user_data ? data_q : DATA_W'(row.code);

  // R10: an unacknowledged write stays on the bus unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)));

  // R11: done follows an acknowledged write and the block is idle with it
  a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_req && bus_ack) && !busy));

  // R12: a request during a running script leaves captured operands alone
  a_r12_refused_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));

  // R1: an unsupported code presented while idle starts nothing
  a_r1_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !op_known(req_cmd)) |=> !busy);

endmodule

// File: tb/test_nor_cmd_seq.sv
module test_nor_cmd_seq;

  localparam int          CLK_PERIOD = 10;
  localparam logic [23:0] BASE16 = 24'h40_0000;
  localparam logic [23:0] BASE8  = 24'h20_0000;
  localparam int          N_ITEMS = 60;

  typedef struct {
    logic [23:0] a;
    logic [15:0] d;
    string       tag;
  } entry_t;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid, req_ready, busy, done, bus_req, bus_ack;
  logic [2:0]  req_cmd;
  logic [19:0] req_addr;
  logic [15:0] req_data, bus_wdata;
  logic [23:0] bus_addr;

  logic        v8, rdy8, busy8, done8, breq8, ack8;
  logic [2:0]  cmd8;
  logic [19:0] addr8;
  logic [15:0] data8, wd8;
  logic [23:0] ba8;

  nor_cmd_seq #(.DEV_WIDTH(16), .BANK_BASE(BASE16)) i_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .done(done), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack));

  nor_cmd_seq #(.DEV_WIDTH(8), .BANK_BASE(BASE8)) i_nor_cmd_seq_b8 (
    .clk(clk), .rst_n(rst_n), .req_valid(v8), .req_ready(rdy8),
    .req_cmd(cmd8), .req_addr(addr8), .req_data(data8),
    .busy(busy8), .done(done8), .bus_req(breq8), .bus_addr(ba8),
    .bus_wdata(wd8), .bus_ack(ack8));

  int nchk = 0;
  int nerr = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic entry_t ent(input logic [23:0] base, input int sh,
                                 input logic [19:0] w, input logic [15:0] d, input string t);
    entry_t e;
    e.a   = base + ({4'b0, w} << sh);
    e.d   = d;
    e.tag = t;
    return e;
  endfunction

  // expected write list of each command, from the requirements
  task automatic build(ref entry_t q[$], input int cmd, input logic [19:0] wa,
                       input logic [15:0] wd, input int sh, input logic [23:0] base);
    if (cmd >= 1 && cmd <= 4) begin
      q.push_back(ent(base, sh, 20'h555, 16'h00AA, "R2"));
      q.push_back(ent(base, sh, 20'h2AA, 16'h0055, "R2"));
    end
    case (cmd)
      0: q.push_back(ent(base, sh, 20'h0, 16'h00F0, "R8"));
      1: q.push_back(ent(base, sh, 20'h555, 16'h0090, "R4"));
      2: begin
        q.push_back(ent(base, sh, 20'h555, 16'h00A0, "R3"));
        q.push_back(ent(base, sh, wa, wd, "R3"));
      end
      3, 4: begin
        q.push_back(ent(base, sh, 20'h555, 16'h0080, "R5"));
        q.push_back(ent(base, sh, 20'h555, 16'h00AA, "R5"));
        q.push_back(ent(base, sh, 20'h2AA, 16'h0055, "R5"));
        if (cmd == 3) q.push_back(ent(base, sh, wa, 16'h0030, "R5"));
        else          q.push_back(ent(base, sh, 20'h555, 16'h0010, "R6"));
      end
      default: q.push_back(ent(base, sh, 20'h055, 16'h0098, "R7"));
    endcase
  endtask

  // directed run on the 8-bit instance (R9 with zero shift)
  task automatic run8(input int cmd, input logic [19:0] wa, input logic [15:0] wd);
    entry_t q8[$];
    build(q8, cmd, wa, wd, 0, BASE8);
    @(negedge clk);
    v8 = 1'b1; cmd8 = 3'(cmd); addr8 = wa; data8 = wd;
    @(negedge clk);
    v8 = 1'b0; ack8 = 1'b1;
    while (q8.size() > 0) begin
      chk(breq8 === 1'b1, "R10 b8 bus_req", 32'(breq8), 32'h1);
      chk(ba8 === q8[0].a, "R9 b8 addr", 32'(ba8), 32'(q8[0].a));
      chk(wd8 === q8[0].d, q8[0].tag, 32'(wd8), 32'(q8[0].d));
      void'(q8.pop_front());
      @(negedge clk);
    end
    ack8 = 1'b0;
    chk(done8 === 1'b1, "R11 b8 done", 32'(done8), 32'h1);
    chk(busy8 === 1'b0, "R11 b8 busy", 32'(busy8), 32'h0);
  endtask

  // behavioural reference for the main instance
  entry_t mq[$];
  bit     mbusy = 1'b0;
  bit     mdone = 1'b0;
  bit     run_main = 1'b0;
  bit     main_fin = 1'b0;
  bit     held = 1'b0;
  int     ptr = 0;
  int     endcnt = 0;
  logic [2:0] pcmd = 3'd0;

  function automatic int item_cmd(int i);
    return i % 6;
  endfunction

  always @(negedge clk) begin
    if (run_main && !main_fin) begin
      bit acc;
      bit item_drv;
      chk(busy === mbusy, "R11 busy", 32'(busy), 32'(mbusy));
      chk(bus_req === mbusy, "R10 bus_req", 32'(bus_req), 32'(mbusy));
      chk(done === mdone, "R11 done", 32'(done), 32'(mdone));
      chk(req_ready === (!mbusy && pcmd < 3'd6), mbusy ? "R12 ready" : "R1 ready",
          32'(req_ready), 32'(!mbusy && pcmd < 3'd6));
      if (mbusy) begin
        chk(bus_addr === mq[0].a, held ? "R10 addr held" : "R9 addr", 32'(bus_addr), 32'(mq[0].a));
        chk(bus_wdata === mq[0].d, mq[0].tag, 32'(bus_wdata), 32'(mq[0].d));
      end
      // stimulus for the coming edge
      bus_ack  = (rnd() % 5) < 3;
      item_drv = 1'b0;
      req_valid = 1'b0;
      if (mbusy && (rnd() % 2 == 0)) begin
        // R12: junk request while busy
        req_valid = 1'b1; req_cmd = 3'(rnd()); req_addr = 20'(rnd()); req_data = 16'(rnd());
      end else if (!mbusy && (rnd() % 6 == 0)) begin
        // R1: unsupported code while idle
        req_valid = 1'b1; req_cmd = 3'd6 + 3'(rnd() % 2); req_addr = 20'(rnd()); req_data = 16'(rnd());
      end else if (ptr < N_ITEMS && (rnd() % 4 != 0)) begin
        req_valid = 1'b1; req_cmd = 3'(item_cmd(ptr));
        req_addr = 20'(rnd()); req_data = 16'(rnd());
        item_drv = 1'b1;
      end
      pcmd = req_cmd;
      acc  = req_valid && !mbusy && (req_cmd < 3'd6);
      held = mbusy && !bus_ack;
      mdone = 1'b0;
      if (mbusy && bus_ack) begin
        void'(mq.pop_front());
        if (mq.size() == 0) begin
          mbusy = 1'b0;
          mdone = 1'b1;
        end
      end
      if (acc) begin
        build(mq, int'(req_cmd), req_addr, req_data, 1, BASE16);
        mbusy = 1'b1;
        if (item_drv) ptr++;
      end
      if (ptr >= N_ITEMS && !mbusy && !acc) begin
        endcnt++;
        if (endcnt > 3) main_fin = 1'b1;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_cmd = 3'd0; req_addr = '0; req_data = '0; bus_ack = 1'b0;
    v8 = 1'b0; cmd8 = 3'd0; addr8 = '0; data8 = '0; ack8 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk(busy === 1'b0, "R13 busy", 32'(busy), 32'h0);
    chk(done === 1'b0, "R13 done", 32'(done), 32'h0);
    chk(bus_req === 1'b0, "R13 bus_req", 32'(bus_req), 32'h0);
    chk(busy8 === 1'b0, "R13 b8 busy", 32'(busy8), 32'h0);
    run8(5, 20'h0, 16'h0);          // R7 query on narrow device
    run8(2, 20'h1_2345, 16'hBEEF);  // R3 program on narrow device
    run8(4, 20'h0, 16'h0);          // R6 chip erase on narrow device
    @(negedge clk);
    run_main = 1'b1;
    wait (main_fin);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule